// File: doc/BRIEF.md
# CAN Message FIFO Window Controller

This block sits between a CAN protocol engine and the CPU. It holds two message queues of four slots each: one carries messages from software to the bus and one carries messages from the bus to software. Software never addresses the slots directly. Each direction has one fixed window made of an ID word, a length code and eight data bytes. To send, software fills the transmit window and then writes 0xFF to the transmit advance register. That copies the window into the next free slot. To receive, software reads the receive window, which always shows the oldest unread message, and then writes 0xFF to the receive advance register to free that slot.

The bus side uses stream ports. The transmit side is a valid/ready source. `tx_valid` is high while transmission is enabled and at least one message is unsent. The message fields stay stable until `tx_ready` is seen high. The receive side is a valid/ready sink. `rx_ready` simply reflects the receive enable, so the engine is held off only while reception is disabled. A push that arrives on a full receive queue is still taken: the oldest message is discarded and an overrun pulse is raised.

Registers are 32-bit words selected by a 4-bit word address, with single-cycle writes and combinational reads:

| Address | Contents |
|---|---|
| 0 to 3 | transmit window: ID, length, data bytes 0 to 3, data bytes 4 to 7 (byte 0 in bits 7:0) |
| 4 to 7 | receive window, same layout, read-only |
| 8 | transmit control |
| 9 | transmit advance |
| 10 | receive control |
| 11 | receive advance |
| 12 | interrupt enable |
| 13 | interrupt status |

Top module: `canfw_window`

## Requirements
- R1: After reset all of the following are zero: the transmit control word, the receive enable, the interrupt enable and status words, and the irq, tx_valid, rx_ready and rx_ovr outputs. The receive control word reads 0x80 (empty flag set).
- R2: A write of 0xFF to address 9 copies the transmit window into the next slot. It also increments the unsent count, which reads in bits 3:1 of address 8. Any other value written to address 9 has no effect.
- R3: A write of 0xFF to address 9 while four messages are unsent is ignored. It sets the sticky overflow flag in bit 4 of address 8. Writing address 8 with bit 4 set clears that flag. Bit 0 of address 8 is the transmit enable.
- R4: tx_valid is high exactly when the transmit enable is set and the unsent count is nonzero. tx_id, tx_len and tx_data show the oldest unsent message and hold steady while tx_ready is low. Each cycle with tx_valid and tx_ready both high removes that message. Messages leave in commit order.
- R5: rx_ready equals the receive enable, which is bit 0 of address 10. A cycle with rx_valid and rx_ready both high stores the message. Bit 7 of address 10 reads 1 exactly when no message is held. Addresses 4 to 7 show the oldest held message.
- R6: A write of 0xFF to address 11 frees the oldest held message and moves the window to the next one. If no message is held, the write is ignored. Other values have no effect.
- R7: A push accepted while four messages are held, with no release in the same cycle, discards the oldest message and keeps the newest. The count stays at four, and rx_ovr is high for the single following cycle. A release and a push in the same cycle on a full queue cause no overrun.
- R8: Status bit 4 (address 13) is set by every accepted push and bit 3 by every transmit handshake. Writing address 13 clears each of these bits written as 0 and keeps each written as 1; a new set event in the same cycle wins. Address 12 holds enable bits at the same positions. irq is high when any status bit has its enable set.
- R9: All 32 bits of the ID word pass through unchanged: the extended flag in bit 31, the remote flag in bit 30, a standard ID in 28:18 and an extended ID in 28:0. Only bits 3:0 of a length write are kept, and the upper bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 4 | Register word address |
| cpu_wdata | input | 32 | Register write data |
| cpu_rdata | output | 32 | Register read data (combinational) |
| tx_valid | output | 1 | Transmit message available |
| tx_ready | input | 1 | Bus engine takes the transmit message |
| tx_id | output | 32 | Transmit message ID word |
| tx_len | output | 4 | Transmit length code |
| tx_data | output | 64 | Transmit data, byte 0 in bits 7:0 |
| rx_valid | input | 1 | Received message offered |
| rx_ready | output | 1 | Receive side accepts messages |
| rx_id | input | 32 | Received message ID word |
| rx_len | input | 4 | Received length code |
| rx_data | input | 64 | Received data, byte 0 in bits 7:0 |
| rx_ovr | output | 1 | One-cycle pulse on receive overrun |
| irq | output | 1 | Interrupt request |

## Verification
A wrong pointer or count inside a queue shows up at the ports within one cycle. The unsent count or the empty flag reads wrong, or tx_valid rises or falls at the wrong time. Data delivered out of commit order only shows when that message reaches the head, at most four handshakes later. A wrong overrun decision shows both as a missing or extra rx_ovr pulse in the next cycle and as a wrong message in the receive window afterwards. Interrupt faults show on irq in the cycle after the event, or after the status write.

// File: rtl/canfw_pkg.sv
package canfw_pkg;
  localparam int ID_W   = 32;
  localparam int LEN_W  = 4;
  localparam int DATA_W = 64;
  localparam int MSG_W  = ID_W + LEN_W + DATA_W;

  localparam logic [3:0] A_TX_ID   = 4'd0;
  localparam logic [3:0] A_TX_LEN  = 4'd1;
  localparam logic [3:0] A_TX_D0   = 4'd2;
  localparam logic [3:0] A_TX_D1   = 4'd3;
  localparam logic [3:0] A_RX_ID   = 4'd4;
  localparam logic [3:0] A_RX_LEN  = 4'd5;
  localparam logic [3:0] A_RX_D0   = 4'd6;
  localparam logic [3:0] A_RX_D1   = 4'd7;
  localparam logic [3:0] A_TX_CTL  = 4'd8;
  localparam logic [3:0] A_TX_ADV  = 4'd9;
  localparam logic [3:0] A_RX_CTL  = 4'd10;
  localparam logic [3:0] A_RX_ADV  = 4'd11;
  localparam logic [3:0] A_IRQ_EN  = 4'd12;
  localparam logic [3:0] A_IRQ_ST  = 4'd13;

  localparam logic [7:0] ADV_KEY   = 8'hFF;
  localparam int BIT_RXF = 4;
  localparam int BIT_TXF = 3;

  typedef struct packed {
    logic [ID_W-1:0]   id;
    logic [LEN_W-1:0]  len;
    logic [DATA_W-1:0] data;
  } msg_t;
endpackage

// File: rtl/canfw_ring.sv
module canfw_ring #(
  parameter int DEPTH     = 4,
  parameter int W         = 100,
  parameter bit OVERWRITE = 1'b0,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head_data,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          lost
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop, drop, rd_adv;

  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign head_data = mem[rd_q];
  assign do_pop = pop & ~empty;

  generate
    if (OVERWRITE) begin : g_ovw
      assign do_push = push;
      assign drop    = push & full & ~do_pop;
    end else begin : g_block
      assign do_push = push & ~full;
      assign drop    = 1'b0;
    end
  endgenerate

  assign rd_adv = do_pop | drop;
  assign lost   = drop;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (rd_adv)  rd_q <= nxt(rd_q);
      if (do_push && !rd_adv)      cnt_q <= cnt_q + 1'b1;
      else if (!do_push && rd_adv) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= push_data;
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  assert_full_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (OVERWRITE && push && full && !pop) |=> full);
  assert_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);
endmodule

// File: rtl/canfw_irq.sv
module canfw_irq #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_ev,
  input  logic            wr_stat,
  input  logic [NSRC-1:0] wr_stat_bits,
  input  logic            wr_en,
  input  logic [NSRC-1:0] wr_en_bits,
  output logic [NSRC-1:0] stat,
  output logic [NSRC-1:0] ena,
  output logic            irq
);
  logic [NSRC-1:0] stat_q, ena_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ena_q  <= '0;
    end else begin
      stat_q <= (wr_stat ? (stat_q & wr_stat_bits) : stat_q) | set_ev;
      if (wr_en) ena_q <= wr_en_bits;
    end
  end

  assign stat = stat_q;
  assign ena  = ena_q;
  assign irq  = |(stat_q & ena_q);

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_chk
      assert_flag_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat_q[i]) |-> $past(set_ev[i]));
      assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stat_q[i]) |-> $past(wr_stat && !wr_stat_bits[i]));
    end
  endgenerate
endmodule

// File: rtl/canfw_window.sv
module canfw_window
  import canfw_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_we,
  input  logic [3:0]  cpu_addr,
  input  logic [31:0] cpu_wdata,
  output logic [31:0] cpu_rdata,
  output logic        tx_valid,
  input  logic        tx_ready,
  output logic [31:0] tx_id,
  output logic [3:0]  tx_len,
  output logic [63:0] tx_data,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic [31:0] rx_id,
  input  logic [3:0]  rx_len,
  input  logic [63:0] rx_data,
  output logic        rx_ovr,
  output logic        irq
);
  logic [ID_W-1:0]   stg_id;
  logic [LEN_W-1:0]  stg_len;
  logic [DATA_W-1:0] stg_data;
  logic              tx_en_q, rx_en_q, tx_ovf_q, rx_ovr_q;
  logic              tx_adv, rx_rel, tx_hs, rx_acc;
  logic              tx_full, tx_empty, rx_full, rx_empty, rx_lost, tx_lost_unused;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  msg_t              tx_in, tx_head, rx_in, rx_head;
  logic [1:0]        ist, ien;

  function automatic logic hit(input logic [3:0] a);
    return cpu_we && (cpu_addr == a);
  endfunction

  assign tx_adv = hit(A_TX_ADV) && (cpu_wdata[7:0] == ADV_KEY);
  assign rx_rel = hit(A_RX_ADV) && (cpu_wdata[7:0] == ADV_KEY);
  assign tx_valid = tx_en_q & ~tx_empty;
  assign tx_hs    = tx_valid & tx_ready;
  assign rx_ready = rx_en_q;
  assign rx_acc   = rx_valid & rx_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_id   <= '0;
      stg_len  <= '0;
      stg_data <= '0;
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tx_ovf_q <= 1'b0;
      rx_ovr_q <= 1'b0;
    end else begin
      if (hit(A_TX_ID))  stg_id          <= cpu_wdata;
      if (hit(A_TX_LEN)) stg_len         <= cpu_wdata[LEN_W-1:0];
      if (hit(A_TX_D0))  stg_data[31:0]  <= cpu_wdata;
      if (hit(A_TX_D1))  stg_data[63:32] <= cpu_wdata;
      if (hit(A_TX_CTL)) tx_en_q         <= cpu_wdata[0];
      if (hit(A_RX_CTL)) rx_en_q         <= cpu_wdata[0];
      if (tx_adv && tx_full)                 tx_ovf_q <= 1'b1;
      else if (hit(A_TX_CTL) && cpu_wdata[4]) tx_ovf_q <= 1'b0;
      rx_ovr_q <= rx_lost;
    end
  end

  assign tx_in = '{id: stg_id, len: stg_len, data: stg_data};
  assign rx_in = '{id: rx_id, len: rx_len, data: rx_data};

  canfw_ring #(.DEPTH(DEPTH), .W(MSG_W), .OVERWRITE(1'b0)) u_tx_ring (
    .clk(clk), .rst_n(rst_n), .push(tx_adv), .push_data(tx_in), .pop(tx_hs),
    .head_data(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty),
    .lost(tx_lost_unused));

  canfw_ring #(.DEPTH(DEPTH), .W(MSG_W), .OVERWRITE(1'b1)) u_rx_ring (
    .clk(clk), .rst_n(rst_n), .push(rx_acc), .push_data(rx_in), .pop(rx_rel),
    .head_data(rx_head), .count(rx_cnt), .full(rx_full), .empty(rx_empty),
    .lost(rx_lost));

  canfw_irq #(.NSRC(2)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_ev({rx_acc, tx_hs}),
    .wr_stat(hit(A_IRQ_ST)), .wr_stat_bits({cpu_wdata[BIT_RXF], cpu_wdata[BIT_TXF]}),
    .wr_en(hit(A_IRQ_EN)), .wr_en_bits({cpu_wdata[BIT_RXF], cpu_wdata[BIT_TXF]}),
    .stat(ist), .ena(ien), .irq(irq));

  assign tx_id   = tx_head.id;
  assign tx_len  = tx_head.len;
  assign tx_data = tx_head.data;
  assign rx_ovr  = rx_ovr_q;

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      A_TX_ID:  cpu_rdata = stg_id;
      A_TX_LEN: cpu_rdata[LEN_W-1:0] = stg_len;
      A_TX_D0:  cpu_rdata = stg_data[31:0];
      A_TX_D1:  cpu_rdata = stg_data[63:32];
      A_RX_ID:  cpu_rdata = rx_head.id;
      A_RX_LEN: cpu_rdata[LEN_W-1:0] = rx_head.len;
      A_RX_D0:  cpu_rdata = rx_head.data[31:0];
      A_RX_D1:  cpu_rdata = rx_head.data[63:32];
      A_TX_CTL: cpu_rdata[4:0] = {tx_ovf_q, 3'(tx_cnt), tx_en_q};
      A_RX_CTL: cpu_rdata[7:0] = {rx_empty, 6'b0, rx_en_q};
      A_IRQ_EN: begin
        cpu_rdata[BIT_RXF] = ien[1];
        cpu_rdata[BIT_TXF] = ien[0];
      end
      A_IRQ_ST: begin
        cpu_rdata[BIT_RXF] = ist[1];
        cpu_rdata[BIT_TXF] = ist[0];
      end
      default:  cpu_rdata = '0;
    endcase
  end

  assert_tx_ovf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_adv && tx_full) |=> tx_ovf_q);
  assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> ($stable(tx_id) && $stable(tx_data) && $stable(tx_len)));
  assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> $past(rx_valid && rx_ready && rx_full));
  assert_ovr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovr |-> (rx_cnt == CW'(DEPTH)));
  assert_tx_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_adv && !tx_full && !tx_hs) |=> (tx_cnt == $past(tx_cnt) + 1'b1));
endmodule

// File: tb/canfw_window_tb.sv
`timescale 1ns/1ps
module canfw_window_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        tx_valid, tx_ready = 1'b0;
  logic [31:0] tx_id;
  logic [3:0]  tx_len;
  logic [63:0] tx_data;
  logic        rx_valid = 1'b0, rx_ready;
  logic [31:0] rx_id = '0;
  logic [3:0]  rx_len = '0;
  logic [63:0] rx_data = '0;
  logic        rx_ovr, irq;

  always #5 clk = ~clk;

  canfw_window u_dut (.*);

  int errors = 0, checks = 0, cyc = 0;
  bit done = 0;

  // behavioural reference
  logic [99:0] txq[$];
  logic [99:0] rxq[$];
  logic [31:0] m_id;
  logic [3:0]  m_len;
  logic [63:0] m_data;
  bit m_txen, m_rxen, m_ovf, m_str, m_stt, m_ier, m_iet, m_ovr;

  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      txq.delete(); rxq.delete();
      m_id = '0; m_len = '0; m_data = '0;
      {m_txen, m_rxen, m_ovf, m_str, m_stt, m_ier, m_iet, m_ovr} = '0;
    end else begin
      bit pop, acc, rel, adv;
      pop = m_txen && txq.size() > 0 && tx_ready;
      acc = m_rxen && rx_valid;
      adv = cpu_we && cpu_addr == 9 && cpu_wdata[7:0] == 8'hFF;
      rel = cpu_we && cpu_addr == 11 && cpu_wdata[7:0] == 8'hFF;
      if (adv && txq.size() == 4) m_ovf = 1;
      else if (cpu_we && cpu_addr == 8 && cpu_wdata[4]) m_ovf = 0;
      if (pop) void'(txq.pop_front());
      if (adv && (txq.size() + (pop ? 1 : 0)) < 4) txq.push_back({m_id, m_len, m_data});
      m_ovr = 0;
      if (rel && rxq.size() > 0) void'(rxq.pop_front());
      if (acc) begin
        if (rxq.size() == 4) begin void'(rxq.pop_front()); m_ovr = 1; end
        rxq.push_back({rx_id, rx_len, rx_data});
      end
      if (cpu_we && cpu_addr == 13) begin m_str &= cpu_wdata[4]; m_stt &= cpu_wdata[3]; end
      m_str |= acc; m_stt |= pop;
      if (cpu_we) case (cpu_addr)
        0: m_id = cpu_wdata;
        1: m_len = cpu_wdata[3:0];
        2: m_data[31:0] = cpu_wdata;
        3: m_data[63:32] = cpu_wdata;
        8: m_txen = cpu_wdata[0];
        10: m_rxen = cpu_wdata[0];
        12: begin m_ier = cpu_wdata[4]; m_iet = cpu_wdata[3]; end
        default: ;
      endcase
    end
  end

  // per-cycle comparison on the low phase
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = m_txen && txq.size() > 0;
      chk("R4 tx_valid", tx_valid, ev);
      if (ev) chk("R4 tx message", {tx_id, tx_len, tx_data}, txq[0]);
      chk("R5 rx_ready", rx_ready, m_rxen);
      chk("R8 irq", irq, (m_str & m_ier) | (m_stt & m_iet));
      chk("R7 rx_ovr", rx_ovr, m_ovr);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  function automatic logic [31:0] mread(input logic [3:0] a);
    logic [99:0] h;
    h = rxq.size() > 0 ? rxq[0] : '0;
    case (a)
      0: return m_id;
      1: return {28'd0, m_len};
      2: return m_data[31:0];
      3: return m_data[63:32];
      4: return h[99:68];
      5: return {28'd0, h[67:64]};
      6: return h[31:0];
      7: return h[63:32];
      8: return {27'd0, m_ovf, 3'(txq.size()), m_txen};
      10: return {24'd0, rxq.size() == 0, 6'd0, m_rxen};
      12: return {27'd0, m_ier, m_iet, 3'd0};
      13: return {27'd0, m_str, m_stt, 3'd0};
      default: return '0;
    endcase
  endfunction

  task automatic rd(string tag, input logic [3:0] a);
    cpu_addr = a;
    #1;
    if (!(a >= 4 && a <= 7 && rxq.size() == 0)) chk(tag, cpu_rdata, mread(a));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    cpu_we = 1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 0;
  endtask

  task automatic stage(input logic [31:0] id, input logic [31:0] len, input logic [63:0] d);
    wr(0, id); wr(1, len); wr(2, d[31:0]); wr(3, d[63:32]);
  endtask

  task automatic push(input logic [31:0] id, input logic [3:0] len, input logic [63:0] d);
    rx_valid = 1; rx_id = id; rx_len = len; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset values
    for (int a = 8; a <= 13; a++) rd("R1 reset register", 4'(a));
    chk("R1 irq", irq, 0);
    chk("R1 tx_valid", tx_valid, 0);

    // R2/R9: commit four messages with transmit disabled
    stage(32'h8000_0000 | 29'h1ABC_DEF0, 32'hFFFF_FFF8, 64'h0807_0605_0403_0201);
    rd("R9 length upper bits", 1);
    wr(9, 32'hFF);
    rd("R2 count after commit", 8);
    wr(9, 32'h7F);
    rd("R2 non-key advance ignored", 8);
    stage(32'h4000_0000 | (11'h5A5 << 18), 4'd0, 64'h0);
    wr(9, 32'hFF);
    stage(11'h123 << 18, 4'd8, 64'hDEAD_BEEF_CAFE_F00D);
    wr(9, 32'hFF);
    stage(32'hC000_0001, 4'd3, 64'h0000_0000_00AA_BBCC);
    wr(9, 32'hFF);
    rd("R2 four unsent", 8);
    // R3 overflow
    stage(32'h1111_1111, 4'd1, 64'h1);
    wr(9, 32'hFF);
    rd("R3 overflow flag set, count kept", 8);
    wr(12, 32'h18);
    // enable transmit, clear overflow; drain with gaps in ready
    wr(8, 32'h11);
    rd("R3 overflow cleared", 8);
    for (int i = 0; i < 12; i++) begin
      tx_ready = (i % 3 == 2);
      @(negedge clk);
    end
    tx_ready = 1;
    repeat (4) @(negedge clk);
    rd("R4 drained", 8);
    rd("R8 tx status", 13);
    wr(13, 32'hFFFF_FFF7);
    rd("R8 tx status cleared", 13);
    tx_ready = 0;

    // R5 receive disabled: push refused
    push(32'h2222_0000, 4'd2, 64'h22);
    rd("R5 disabled keeps empty", 10);
    wr(10, 32'h1);
    // R6 release on empty ignored
    wr(11, 32'hFF);
    push(32'h8000_00AA, 4'd5, 64'h0505_0505_05);
    rd("R5 not empty", 10);
    rd("R9 rx id", 4);
    rd("R5 rx len", 5);
    rd("R5 rx data lo", 6);
    wr(13, 32'hFFFF_FFEF);
    rd("R8 rx status cleared", 13);
    wr(11, 32'h00);
    rd("R6 non-key release ignored", 4);
    for (int i = 1; i <= 5; i++) push(32'h100 + i, 4'(i), 64'(i * 7));
    @(negedge clk);
    rd("R7 oldest after overrun", 4);
    rd("R7 data after overrun", 6);
    // full queue: release and push together, no overrun
    rx_valid = 1; rx_id = 32'h0000_0777; rx_len = 4'd7; rx_data = 64'h77;
    cpu_we = 1; cpu_addr = 11; cpu_wdata = 32'hFF;
    @(negedge clk);
    rx_valid = 0; cpu_we = 0;
    @(negedge clk);
    rd("R7 window after release+push", 4);
    for (int i = 0; i < 4; i++) begin
      rd("R6 window order", 4);
      wr(11, 32'hFF);
    end
    rd("R6 empty after releases", 10);
    wr(11, 32'hFF);
    push(32'h0000_0999, 4'd9, 64'h99);
    rd("R6 pointers intact after empty release", 4);
    rd("R6 single held", 10);
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule